// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a 32-bit host write port and a register file whose entries are mostly wider than one host write. Every host write arrives as one dword with a byte address. The block sorts each write by its in-page offset into one of four classes. Plain 32-bit registers pass straight through. Ordinary 128-bit registers and 64-bit memory words are gathered dword by dword in a single shared collector and are committed whole. Write-only descriptor-pointer registers commit as soon as their top dword is written.

A commit appears on the commit port in the same cycle as the host write that causes it. The port carries a one-cycle strobe, the base byte address of the target, the 128-bit assembled value and a class code. Per-queue registers repeat on every page of `2**PAGE_SHIFT` bytes, which is 0x2000 by default. Decoding therefore uses only the address bits below the page boundary, and the page bits pass through untouched into the commit address.

The collector holds one target at a time. The host has to serialise its wide accesses. A partial write to a different ordinary target throws away whatever was gathered before.

Top module: `wide_write_collector`

## Requirements
- R1: After reset the collector is empty and `cm_valid` is 0. The first host write after reset is decoded against an empty collector.
- R2: For an ordinary 128-bit register (any in-page offset below 0x1000 that is neither plain nor descriptor), the commit has class code 1 and fires in the cycle of the write that supplies the last missing dword, whatever the order of the dwords. It carries base address `addr & ~0xF`, and dword n of the data sits at bits [32n+31:32n].
- R3: Writing a dword of the register already being collected a second time overwrites the earlier value and does not commit by itself.
- R4: In-page offsets from 0x1000 upward are 64-bit memory words with class code 2. A commit needs both dwords. It carries base address `addr & ~0x7`, and the upper 64 data bits are zero.
- R5: In-page offsets 0x180, 0x200, 0x400 and 0x420 are plain registers with class code 0. They commit in the cycle of the write with `wr_data` in bits [31:0] and zero above. Apart from R8, they leave a collection in progress untouched.
- R6: Descriptor registers occupy the 16-byte blocks at in-page offsets 0x830 and 0xA10. A write to the top dword (+0xC) always commits, with class code 3. Dwords already collected for that register are kept, and every dword not supplied reads as zero.
- R7: A write to a non-top dword of a descriptor register is dropped while the collector holds data for another target. The collector keeps its contents, so that target can still complete.
- R8: A write to in-page offset 0x420 on page 0 empties the collector. The same write on any other page does not.
- R9: A partial write to an ordinary register or memory word that differs from the collector's current target restarts collection on the new target. The earlier dwords are lost.
- R10: The class decode looks only at the address bits below `PAGE_SHIFT`. Commit addresses keep the page bits of the host address, so the same register on different pages counts as a different target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write strobe, one dword per cycle |
| wr_addr | input | ADDR_W | Host byte address (bits [1:0] ignored) |
| wr_data | input | 32 | Host write data |
| cm_valid | output | 1 | One-cycle commit strobe toward the register file |
| cm_addr | output | ADDR_W | Base byte address of the committed target |
| cm_data | output | 128 | Committed value, dword n at bits [32n+31:32n] |
| cm_kind | output | 2 | 0 plain, 1 wide register, 2 memory word, 3 descriptor |

## Verification
A corrupted collector mask or base never shows on the port by itself. It surfaces at the next write that ought to complete or extend a collection: a commit goes missing, fires a dword too early, or carries stale dwords. A descriptor top-dword commit exposes the collector contents directly in its low 96 bits. The bench therefore compares every host write against a behavioural model at once and mixes directed sequences with a long random stream over a few overlapping targets. Any divergence is then seen within a few writes.

// File: rtl/wide_write_collector.sv
module wide_write_collector #(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 13,
  parameter int DESC_A     = 'h830,
  parameter int DESC_B     = 'hA10,
  parameter int PLAIN_0    = 'h180,
  parameter int PLAIN_1    = 'h200,
  parameter int PLAIN_2    = 'h400,
  parameter int TIMER_OFS  = 'h420,
  parameter int MEM_LO     = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [127:0]      cm_data,
  output logic [1:0]        cm_kind
);
  localparam logic [1:0] K_PLAIN = 2'd0, K_WIDE = 2'd1, K_MEM = 2'd2, K_DESC = 2'd3;
  localparam logic [ADDR_W-1:0] M16 = ~ADDR_W'(15);
  localparam logic [ADDR_W-1:0] M8  = ~ADDR_W'(7);
  localparam logic [ADDR_W-1:0] M4  = ~ADDR_W'(3);

  logic [ADDR_W-1:0] col_base;
  logic [3:0]        col_mask;
  logic [127:0]      col_data;

  logic [31:0] ofs, ofs_dw, ofs_blk;
  assign ofs     = 32'(wr_addr[PAGE_SHIFT-1:0]);
  assign ofs_dw  = ofs & ~32'd3;
  assign ofs_blk = ofs & ~32'd15;

  logic page_zero, is_timer, is_plain, is_desc, is_mem;
  assign page_zero = (wr_addr[ADDR_W-1:PAGE_SHIFT] == '0);
  assign is_timer  = (ofs_dw == TIMER_OFS);
  assign is_plain  = is_timer || ofs_dw == PLAIN_0 || ofs_dw == PLAIN_1 || ofs_dw == PLAIN_2;
  assign is_desc   = !is_plain && (ofs_blk == DESC_A || ofs_blk == DESC_B);
  assign is_mem    = !is_plain && !is_desc && (ofs >= MEM_LO);

  logic [ADDR_W-1:0] tgt_base;
  logic [1:0]        slot;
  logic [3:0]        full_mask, mask_mg;
  logic              other, top_wr, complete, drop;
  logic [127:0]      data_mg;

  assign tgt_base  = is_mem ? (wr_addr & M8) : (wr_addr & M16);
  assign slot      = is_mem ? {1'b0, wr_addr[2]} : wr_addr[3:2];
  assign full_mask = is_mem ? 4'b0011 : 4'b1111;
  assign other     = (col_mask != 4'b0) && (col_base != tgt_base);
  assign mask_mg   = (other ? 4'b0 : col_mask) | (4'b1 << slot);
  assign top_wr    = is_desc && (slot == 2'd3);
  assign drop      = is_desc && !top_wr && other;
  assign complete  = !is_plain && !is_desc && (mask_mg == full_mask);

  always_comb begin
    data_mg = other ? '0 : col_data;
    data_mg[slot*32 +: 32] = wr_data;
  end

  assign cm_valid = wr_valid && (is_plain || top_wr || complete);
  assign cm_addr  = is_plain ? (wr_addr & M4) : tgt_base;
  assign cm_kind  = is_plain ? K_PLAIN : is_desc ? K_DESC : is_mem ? K_MEM : K_WIDE;
  assign cm_data  = is_plain ? {96'b0, wr_data} :
                    is_mem   ? {64'b0, data_mg[63:0]} : data_mg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_base <= '0;
      col_mask <= '0;
      col_data <= '0;
    end else if (wr_valid) begin
      if ((is_plain && is_timer && page_zero) || (top_wr && !other) || complete) begin
        col_base <= '0;
        col_mask <= '0;
        col_data <= '0;
      end else if (!is_plain && !top_wr && !drop) begin
        col_base <= tgt_base;
        col_mask <= mask_mg;
        col_data <= data_mg;
      end
    end
  end

  a_r2_commit_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> wr_valid);
  a_r2_empty_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && (cm_kind == K_WIDE || cm_kind == K_MEM)) |=> (col_mask == 4'b0));
  a_r4_mem_two_dwords: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_kind == K_MEM) |-> (cm_data[127:64] == 64'b0 && cm_addr[2:0] == 3'b0));
  a_r5_plain_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_kind == K_PLAIN) |-> (cm_data[127:32] == 96'b0));
  a_r6_desc_top_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && top_wr) |-> (cm_valid && cm_addr[3:0] == 4'b0));
  a_r7_drop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && drop) |=> ($stable(col_mask) && $stable(col_base) && $stable(col_data)));
  a_r8_timer_page0_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && is_timer && page_zero) |=> (col_mask == 4'b0));
endmodule

// File: tb/wide_write_collector_tb.sv
module wide_write_collector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          cm_valid;
  logic [AW-1:0] cm_addr;
  logic [127:0]  cm_data;
  logic [1:0]    cm_kind;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_write_collector u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_kind(cm_kind));

  // reference model state
  int          mb;
  bit [3:0]    mm;
  logic [31:0] md [4];

  task automatic model_clear();
    mb = 0; mm = 4'b0;
    for (int i = 0; i < 4; i++) md[i] = 32'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string req);
    int ofs, dw, base, s, nw, ek;
    bit page0, plain, desc, mem, other, ev;
    logic [31:0] tm [4];
    bit [3:0] tmask;
    logic [127:0] ed;
    int ea;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d;
    #1;
    ofs = a % 'h2000; dw = ofs - (ofs % 4); page0 = (a / 'h2000) == 0;
    plain = (dw == 'h180 || dw == 'h200 || dw == 'h400 || dw == 'h420);
    desc  = !plain && ((ofs - ofs % 16) == 'h830 || (ofs - ofs % 16) == 'hA10);
    mem   = !plain && !desc && ofs >= 'h1000;
    ev = 0; ea = 0; ed = '0; ek = 0;
    if (plain) begin
      ev = 1; ea = a - a % 4; ed = {96'b0, d}; ek = 0;
      if (dw == 'h420 && page0) model_clear();
    end else begin
      base = mem ? a - a % 8 : a - a % 16;
      s    = mem ? (a / 4) % 2 : (a / 4) % 4;
      nw   = mem ? 2 : 4;
      other = (mm != 0) && (mb != base);
      if (!(desc && s != 3 && other)) begin
        for (int i = 0; i < 4; i++) tm[i] = other ? 32'b0 : md[i];
        tmask = other ? 4'b0 : mm;
        tm[s] = d; tmask[s] = 1'b1;
        ev = desc ? (s == 3) : (tmask == ((1 << nw) - 1));
        ea = base;
        ek = desc ? 3 : mem ? 2 : 1;
        ed = mem ? {64'b0, tm[1], tm[0]} : {tm[3], tm[2], tm[1], tm[0]};
        if (desc && s == 3) begin
          if (!other) model_clear();
        end else if (ev) model_clear();
        else begin
          mb = base; mm = tmask;
          for (int i = 0; i < 4; i++) md[i] = tm[i];
        end
      end
    end
    checks++;
    if (cm_valid !== ev || (ev && (cm_addr !== AW'(ea) || cm_data !== ed || cm_kind !== 2'(ek)))) begin
      fails++;
      $display("FAIL %s addr=%h: actual v=%b a=%h k=%0d d=%h expected v=%b a=%h k=%0d d=%h",
               req, a, cm_valid, cm_addr, cm_kind, cm_data, ev, AW'(ea), ek, ed);
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic idle(input string req);
    @(negedge clk); #1;
    checks++;
    if (cm_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: actual cm_valid=%b expected 0", req, cm_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1");
    // R1 + R6: top-dword descriptor write straight after reset, low bits zero
    wr('h83C, 32'hD0D0_0001, "R1");
    // R2: out-of-order gathering of an ordinary register
    wr('h048, 32'h2222_0002, "R2");
    wr('h040, 32'h0000_0000, "R2");
    wr('h04C, 32'h3333_0003, "R2");
    wr('h044, 32'h1111_0001, "R2");
    // R3: overwrite of an already collected dword
    wr('h060, 32'hAAAA_0000, "R3");
    wr('h060, 32'hBBBB_0000, "R3");
    wr('h064, 32'hBBBB_0001, "R3");
    wr('h068, 32'hBBBB_0002, "R3");
    wr('h06C, 32'hBBBB_0003, "R3");
    // R4: memory word
    wr('h100C, 32'h4444_0001, "R4");
    wr('h1008, 32'h4444_0000, "R4");
    // R5: plain writes in the middle of a collection, page 1
    wr('h0100, 32'h5555_0000, "R5");
    wr('h2180, 32'h5A5A_0180, "R5");
    wr('h2200, 32'h5A5A_0200, "R5");
    wr('h2400, 32'h5A5A_0400, "R5");
    wr('h2420, 32'h5A5A_0420, "R5");
    wr('h0104, 32'h5555_0001, "R5");
    wr('h0108, 32'h5555_0002, "R5");
    wr('h010C, 32'h5555_0003, "R5");
    // R6: descriptor with partial low dwords
    wr('hA10, 32'h6666_0000, "R6");
    wr('hA14, 32'h6666_0001, "R6");
    wr('hA1C, 32'h6666_0003, "R6");
    // R7: descriptor non-top write dropped while another target is held
    wr('h050, 32'h7777_0000, "R7");
    wr('h4834, 32'hDEAD_BEEF, "R7");
    wr('h054, 32'h7777_0001, "R7");
    wr('h058, 32'h7777_0002, "R7");
    wr('h05C, 32'h7777_0003, "R7");
    // R8: timer on page 0 invalidates, on page 3 does not
    wr('h070, 32'h8888_0000, "R8");
    wr('h074, 32'h8888_0001, "R8");
    wr('h420, 32'h0000_0420, "R8");
    wr('h078, 32'h8888_0002, "R8");
    wr('h07C, 32'h8888_0003, "R8");
    wr('h070, 32'h8888_1000, "R8");
    wr('h074, 32'h8888_1001, "R8");
    wr('h070, 32'h8989_0000, "R8");
    wr('h6420, 32'h0003_0420, "R8");
    wr('h074, 32'h8989_0001, "R8");
    wr('h078, 32'h8989_0002, "R8");
    wr('h07C, 32'h8989_0003, "R8");
    // R9: interruption by another ordinary target restarts
    wr('h080, 32'h9999_0000, "R9");
    wr('h090, 32'h9999_1000, "R9");
    wr('h084, 32'h9999_0001, "R9");
    wr('h088, 32'h9999_0002, "R9");
    wr('h08C, 32'h9999_0003, "R9");
    wr('h080, 32'h9999_0010, "R9");
    // R10: same offset on different pages are different targets
    wr('hA830, 32'hAAAA_0000, "R10");
    wr('h2830, 32'hAAAA_2000, "R10");
    wr('hA83C, 32'hAAAA_0003, "R10");
    idle("R10");
    // mixed random stream over overlapping targets
    for (int n = 0; n < 600; n++) begin
      int pick, pg, a;
      pick = $urandom_range(0, 7);
      pg   = $urandom_range(0, 1);
      case (pick)
        0, 1: a = 'h040 + 4 * $urandom_range(0, 3);
        2:    a = 'h0C0 + 4 * $urandom_range(0, 3);
        3:    a = 'h1000 + 4 * $urandom_range(0, 3);
        4:    a = 'h830 + 4 * $urandom_range(0, 3);
        5:    a = 'hA10 + 4 * $urandom_range(0, 3);
        6:    a = ($urandom_range(0, 1) == 0) ? 'h420 : 'h180;
        default: a = 'h040 + 4 * $urandom_range(0, 3);
      endcase
      wr(pg * 'h2000 + a, $urandom, "R2 R6 R7 R9 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule